// File: doc/BRIEF.md
# Command Packet Framer

This block sits on the rendering command port. It takes a stream of 32-bit words over a valid/ready handshake and groups them into packets. The opcode in the top byte of a packet's first word sets the packet's length. Each finished packet is held in a twelve-word buffer. A one-cycle completion strobe then presents the opcode, the word count and the buffered words to the downstream rasteriser.

The image-upload header is handled differently. Once its third word arrives, the block computes the payload size from the width and height it carries. It then swallows that many pixel words without buffering them. The single-word environment commands are decoded into registers that the status logic reads: drawing mode, texture window, the two drawing-area corners, drawing offset and mask control. A clear pulse from the control side abandons whatever is in progress.

Top module: `pkt_framer`

## Requirements
- R1: When no packet is in progress, the top byte of an accepted word is the opcode and sets the packet length. Opcodes 0x00, 0x01 and 0xE1 to 0xE6 take 1 word. Opcodes 0xA0 and 0xC0 take 3 words. 0x28 takes 5, 0x30 takes 6, 0x38 takes 8 and 0x2C takes 9. `pkt_len` equals that count while `pkt_done` is high.
- R2: The cycle after the last word of a packet is accepted, `pkt_done` is high for exactly one cycle and `in_ready` is low. During that cycle `pkt_opcode` shows the opcode. Word k of the packet appears at `pkt_words[32k+31:32k]`, and all unused slots read zero.
- R3: An opcode outside the list in R1 is treated as a one-word packet. `bad_op` is high together with its `pkt_done`.
- R4: After an 0xA0 packet whose third word holds width W in bits 15:0 and height H in bits 31:16, with W times H nonzero, `in_upload` goes high. The next ceil(W*H/2) accepted words are consumed without raising `pkt_done`. `in_upload` then falls, and the next word is parsed as a new opcode.
- R5: An 0xA0 packet with W or H equal to zero leaves `in_upload` low, and the next word is parsed as an opcode.
- R6: While `clr` is high, `in_ready` is low. The cycle after `clr`, the block is out of upload mode, `pkt_len` is 0 and `pkt_done` is low. Any partly received packet is dropped, so the next word is parsed as an opcode.
- R7: Opcode 0xE1 copies bits 13:0 of its word to `dmode`. The fields are: page X in bits 3:0, page Y in bit 4, blending in bits 6:5, texture depth in bits 8:7, dither in bit 9, draw-to-display in bit 10, texture disable in bit 11, X flip in bit 12 and Y flip in bit 13. A texture depth of 3 leaves `dmode` unchanged and raises `bad_op`.
- R8: Opcode 0xE2 copies bits 19:0 of its word to `texwin`. The fields are four 5-bit groups at bits 4:0, 9:5, 14:10 and 19:15.
- R9: Opcode 0xE3 sets `area_x0` from bits 9:0 and `area_y0` from bits 19:10. Opcode 0xE4 sets `area_x1` and `area_y1` from the same bit positions.
- R10: Opcode 0xE5 takes X from bits 10:0 and Y from bits 21:11 as 11-bit two's-complement values. It presents them sign-extended to 16 bits on `offs_x` and `offs_y`.
- R11: Opcode 0xE6 sets `mask_force` from bit 0 and `mask_keep` from bit 1.
- R12: Environment registers take their new values in the same cycle that `pkt_done` is shown.
- R13: After reset, every output register is zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_word | input | 32 | Command-port word |
| in_valid | input | 1 | Word valid |
| in_ready | output | 1 | Word accepted when high with in_valid |
| clr | input | 1 | Abandon the packet or upload in progress |
| pkt_done | output | 1 | One-cycle packet-complete strobe |
| pkt_opcode | output | 8 | Opcode of the finished packet |
| pkt_len | output | 4 | Words held in the buffer |
| pkt_words | output | 384 | Twelve buffered words, word 0 lowest |
| bad_op | output | 1 | Unknown opcode or invalid texture depth |
| in_upload | output | 1 | Consuming image payload words |
| dmode | output | 14 | Drawing mode fields |
| texwin | output | 20 | Texture window fields |
| area_x0 | output | 10 | Drawing area left |
| area_y0 | output | 10 | Drawing area top |
| area_x1 | output | 10 | Drawing area right |
| area_y1 | output | 10 | Drawing area bottom |
| offs_x | output | 16 | Sign-extended X offset |
| offs_y | output | 16 | Sign-extended Y offset |
| mask_force | output | 1 | Force mask bit on writes |
| mask_keep | output | 1 | Preserve masked pixels |

## Verification
Every cycle, the assertions check the handshake and strobe rules. `in_ready` must be low during `pkt_done` and `clr`, the strobe must last one cycle, `bad_op` must pair with a strobe, no strobe may appear inside an upload, the buffer count must stay bounded, and the offset must be properly sign-extended. Only the bench's scenarios can show that each opcode's length is right and that the upload payload count matches width times height. The same holds for the words landing in the correct buffer slots, for each environment field reaching its register, and for a clear dropping a half-received packet.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  typedef enum logic {MODE_CMD = 1'b0, MODE_IMG = 1'b1} mode_e;

  localparam logic [7:0] OP_UPLOAD = 8'hA0;
  localparam logic [7:0] OP_DMODE  = 8'hE1;
  localparam logic [7:0] OP_TWIN   = 8'hE2;
  localparam logic [7:0] OP_AREA0  = 8'hE3;
  localparam logic [7:0] OP_AREA1  = 8'hE4;
  localparam logic [7:0] OP_OFFS   = 8'hE5;
  localparam logic [7:0] OP_MASK   = 8'hE6;

  // Packet length in words; zero marks an opcode the framer does not know.
  function automatic logic [3:0] op_words(input logic [7:0] op);
    logic [3:0] n;
    case (op)
      8'h00, 8'h01, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6: n = 4'd1;
      8'hA0, 8'hC0: n = 4'd3;
      8'h28:        n = 4'd5;
      8'h30:        n = 4'd6;
      8'h38:        n = 4'd8;
      8'h2C:        n = 4'd9;
      default:      n = 4'd0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/pkt_len_lut.sv
module pkt_len_lut
  import pkt_framer_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic [7:0]       op,
  output logic [LEN_W-1:0] len,
  output logic             known
);
  logic [3:0] raw;
  always_comb begin
    raw   = op_words(op);
    known = (raw != 4'd0);
    len   = known ? LEN_W'(raw) : LEN_W'(1);
  end
endmodule

// File: rtl/pkt_env_regs.sv
module pkt_env_regs
  import pkt_framer_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] word,
  output logic [13:0]       dmode,
  output logic [19:0]       texwin,
  output logic [9:0]        area_x0,
  output logic [9:0]        area_y0,
  output logic [9:0]        area_x1,
  output logic [9:0]        area_y1,
  output logic [OFF_W-1:0]  offs_x,
  output logic [OFF_W-1:0]  offs_y,
  output logic              mask_force,
  output logic              mask_keep
);
  localparam int EXT = OFF_W - 11;

  logic [7:0] op;
  logic       dm_en, tw_en, a0_en, a1_en, of_en, mk_en;

  always_comb begin
    op    = word[WORD_W-1 -: 8];
    dm_en = we && (op == OP_DMODE) && (word[8:7] != 2'b11);
    tw_en = we && (op == OP_TWIN);
    a0_en = we && (op == OP_AREA0);
    a1_en = we && (op == OP_AREA1);
    of_en = we && (op == OP_OFFS);
    mk_en = we && (op == OP_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dmode      <= '0;
      texwin     <= '0;
      area_x0    <= '0;
      area_y0    <= '0;
      area_x1    <= '0;
      area_y1    <= '0;
      offs_x     <= '0;
      offs_y     <= '0;
      mask_force <= 1'b0;
      mask_keep  <= 1'b0;
    end else begin
      if (dm_en) dmode  <= word[13:0];
      if (tw_en) texwin <= word[19:0];
      if (a0_en) begin
        area_x0 <= word[9:0];
        area_y0 <= word[19:10];
      end
      if (a1_en) begin
        area_x1 <= word[9:0];
        area_y1 <= word[19:10];
      end
      if (of_en) begin
        offs_x <= {{EXT{word[10]}}, word[10:0]};
        offs_y <= {{EXT{word[21]}}, word[21:11]};
      end
      if (mk_en) begin
        mask_force <= word[0];
        mask_keep  <= word[1];
      end
    end
  end
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import pkt_framer_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BUF_WORDS = 12,
  parameter int LEN_W     = 4,
  parameter int REM_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [WORD_W-1:0]           in_word,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic                        clr,
  input  logic [LEN_W-1:0]            lut_len,
  input  logic                        lut_known,
  output logic [7:0]                  lut_op,
  output logic                        env_we,
  output logic                        pkt_done,
  output logic [7:0]                  pkt_opcode,
  output logic [LEN_W-1:0]            pkt_len,
  output logic [BUF_WORDS*WORD_W-1:0] pkt_words,
  output logic                        bad_op,
  output logic                        in_upload
);
  mode_e             mode_q, mode_d;
  logic [REM_W-1:0]  rem_q, rem_d, rem_after, rem_eff;
  logic [LEN_W-1:0]  len_q, len_d, wr_idx;
  logic [7:0]        op_q, op_d, cur_op;
  logic              done_q, done_d, bad_q, bad_d;
  logic              acc, acc_cmd, start;
  logic [31:0]       area;
  logic [REM_W:0]    half;

  always_comb begin
    lut_op    = in_word[WORD_W-1 -: 8];
    in_ready  = !done_q && !clr;
    acc       = in_valid && in_ready;
    start     = (rem_q == '0);
    acc_cmd   = acc && (mode_q == MODE_CMD);
    env_we    = acc_cmd && start;
    wr_idx    = start ? '0 : len_q;
    cur_op    = start ? lut_op : op_q;
    rem_eff   = start ? REM_W'(lut_len) : rem_q;
    rem_after = rem_eff - 1'b1;
    area      = 32'(in_word[15:0]) * 32'(in_word[31:16]);
    half      = ({1'b0, REM_W'(area)} + 1'b1) >> 1;

    mode_d = mode_q;
    rem_d  = rem_q;
    len_d  = len_q;
    op_d   = op_q;
    done_d = 1'b0;
    bad_d  = 1'b0;
    if (clr) begin
      mode_d = MODE_CMD;
      rem_d  = '0;
      len_d  = '0;
    end else if (acc && mode_q == MODE_IMG) begin
      rem_d = rem_q - 1'b1;
      if (rem_q == REM_W'(1)) mode_d = MODE_CMD;
    end else if (acc_cmd) begin
      if (start) op_d = lut_op;
      len_d = start ? LEN_W'(1) : len_q + 1'b1;
      rem_d = rem_after;
      if (rem_after == '0) begin
        done_d = 1'b1;
        bad_d  = start && (!lut_known ||
                 (lut_op == OP_DMODE && in_word[8:7] == 2'b11));
        if (cur_op == OP_UPLOAD && half[REM_W-1:0] != '0) begin
          mode_d = MODE_IMG;
          rem_d  = half[REM_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_CMD;
      rem_q  <= '0;
      len_q  <= '0;
      op_q   <= '0;
      done_q <= 1'b0;
      bad_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      rem_q  <= rem_d;
      len_q  <= len_d;
      op_q   <= op_d;
      done_q <= done_d;
      bad_q  <= bad_d;
    end
  end

  for (genvar gi = 0; gi < BUF_WORDS; gi++) begin : g_slot
    logic              we;
    logic [WORD_W-1:0] d, q;
    always_comb begin
      we = clr || (acc_cmd && (start || wr_idx == LEN_W'(gi)));
      d  = (!clr && wr_idx == LEN_W'(gi)) ? in_word : '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
    end
    assign pkt_words[gi*WORD_W +: WORD_W] = q;
  end

  assign pkt_done   = done_q;
  assign pkt_opcode = op_q;
  assign pkt_len    = len_q;
  assign bad_op     = bad_q;
  assign in_upload  = (mode_q == MODE_IMG);
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pkt_framer_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int BUF_WORDS = 12,
  parameter int OFF_W     = 16,
  localparam int LEN_W    = $clog2(BUF_WORDS + 1),
  localparam int BUF_BITS = BUF_WORDS * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WORD_W-1:0]   in_word,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                clr,
  output logic                pkt_done,
  output logic [7:0]          pkt_opcode,
  output logic [LEN_W-1:0]    pkt_len,
  output logic [BUF_BITS-1:0] pkt_words,
  output logic                bad_op,
  output logic                in_upload,
  output logic [13:0]         dmode,
  output logic [19:0]         texwin,
  output logic [9:0]          area_x0,
  output logic [9:0]          area_y0,
  output logic [9:0]          area_x1,
  output logic [9:0]          area_y1,
  output logic [OFF_W-1:0]    offs_x,
  output logic [OFF_W-1:0]    offs_y,
  output logic                mask_force,
  output logic                mask_keep
);
  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  logic [7:0]       lut_op;
  logic [LEN_W-1:0] lut_len;
  logic             lut_known, env_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  pkt_len_lut #(.LEN_W(LEN_W)) u_lut (
    .op(lut_op), .len(lut_len), .known(lut_known)
  );

  pkt_seq #(
    .WORD_W(WORD_W), .BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W), .REM_W(32)
  ) u_seq (
    .clk(clk), .rst_n(rst_s_n), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .clr(clr), .lut_len(lut_len), .lut_known(lut_known),
    .lut_op(lut_op), .env_we(env_we), .pkt_done(pkt_done),
    .pkt_opcode(pkt_opcode), .pkt_len(pkt_len), .pkt_words(pkt_words),
    .bad_op(bad_op), .in_upload(in_upload)
  );

  pkt_env_regs #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_env (
    .clk(clk), .rst_n(rst_s_n), .we(env_we), .word(in_word),
    .dmode(dmode), .texwin(texwin), .area_x0(area_x0), .area_y0(area_y0),
    .area_x1(area_x1), .area_y1(area_y1), .offs_x(offs_x), .offs_y(offs_y),
    .mask_force(mask_force), .mask_keep(mask_keep)
  );
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk #(
  parameter int BUF_WORDS = 12,
  parameter int LEN_W     = 4,
  parameter int OFF_W     = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             in_ready,
  input logic             pkt_done,
  input logic [7:0]       pkt_opcode,
  input logic [LEN_W-1:0] pkt_len,
  input logic             bad_op,
  input logic             in_upload,
  input logic [OFF_W-1:0] offs_x,
  input logic [OFF_W-1:0] offs_y
);
  AST_DONE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> !in_ready);  // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done);  // R2
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_len <= LEN_W'(BUF_WORDS));  // R2
  AST_BAD_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> pkt_done);  // R3
  AST_BAD_ONE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_op |-> pkt_len == LEN_W'(1));  // R3
  AST_NO_DONE_IN_UPLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_upload && $past(in_upload)) |-> !pkt_done);  // R4
  AST_CLR_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !in_ready);  // R6
  AST_CLR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!in_upload && !pkt_done && pkt_len == '0));  // R6
  AST_OFFS_SIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (offs_x[OFF_W-1:11] == {(OFF_W-11){offs_x[10]}}) &&
    (offs_y[OFF_W-1:11] == {(OFF_W-11){offs_y[10]}}));  // R10
endmodule

bind pkt_framer pkt_framer_chk #(
  .BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .in_ready(in_ready),
  .pkt_done(pkt_done), .pkt_opcode(pkt_opcode), .pkt_len(pkt_len),
  .bad_op(bad_op), .in_upload(in_upload), .offs_x(offs_x), .offs_y(offs_y)
);

// File: tb/pkt_framer_tb.sv
module pkt_framer_tb;
  logic         clk, rst_n, in_valid, clr;
  logic [31:0]  in_word;
  logic         in_ready, pkt_done, bad_op, in_upload;
  logic [7:0]   pkt_opcode;
  logic [3:0]   pkt_len;
  logic [383:0] pkt_words;
  logic [13:0]  dmode;
  logic [19:0]  texwin;
  logic [9:0]   area_x0, area_y0, area_x1, area_y1;
  logic [15:0]  offs_x, offs_y;
  logic         mask_force, mask_keep;
  int           n_chk, n_fail;

  pkt_framer u_dut (
    .clk(clk), .rst_n(rst_n), .in_word(in_word), .in_valid(in_valid),
    .in_ready(in_ready), .clr(clr), .pkt_done(pkt_done),
    .pkt_opcode(pkt_opcode), .pkt_len(pkt_len), .pkt_words(pkt_words),
    .bad_op(bad_op), .in_upload(in_upload), .dmode(dmode), .texwin(texwin),
    .area_x0(area_x0), .area_y0(area_y0), .area_x1(area_x1),
    .area_y1(area_y1), .offs_x(offs_x), .offs_y(offs_y),
    .mask_force(mask_force), .mask_keep(mask_keep)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_words(input logic [7:0] op);
    case (op)
      8'h00, 8'h01, 8'hE1, 8'hE2, 8'hE3, 8'hE4, 8'hE5, 8'hE6: return 1;
      8'hA0, 8'hC0: return 3;
      8'h28: return 5;
      8'h30: return 6;
      8'h38: return 8;
      8'h2C: return 9;
      default: return 0;
    endcase
  endfunction

  // Offer one word; returns after the edge that accepts it.
  task automatic put(input logic [31:0] w);
    @(negedge clk);
    in_word  = w;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic env_cmd(input logic [31:0] w);
    put(w);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; clr = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(in_ready && !pkt_done && !in_upload && pkt_len == 0 && pkt_words == '0
        && dmode == 0 && offs_x == 0 && !mask_force, "R13", 0, 0);

    // R1 R3 R5: sweep every opcode
    for (int op = 0; op < 256; op++) begin
      int n;
      n = exp_words(8'(op));
      if (n == 0) begin
        put({8'(op), 24'h123456});
        @(negedge clk);
        chk(pkt_done && bad_op && pkt_len == 1 && pkt_opcode == 8'(op),
            "R3", {pkt_done, bad_op, pkt_len}, {2'b11, 4'd1});
      end else begin
        for (int k = 0; k < n; k++)
          put(k == 0 ? {8'(op), 24'h000021} : (k == 2 ? 32'h0007_0000 : 32'h0 + k));
        @(negedge clk);
        chk(pkt_done && !bad_op && pkt_len == 4'(n) && pkt_opcode == 8'(op),
            "R1", {pkt_opcode, pkt_len}, {8'(op), 4'(n)});
        if (op == 8'hA0)
          chk(!in_upload, "R5", in_upload, 0);
      end
    end

    // R2 buffer contents and zeroed slots
    for (int k = 0; k < 9; k++) put(k == 0 ? 32'h2C00_00AA : 32'h0101_0101 * k);
    @(negedge clk);
    for (int k = 0; k < 12; k++) begin
      logic [31:0] e;
      e = (k == 0) ? 32'h2C00_00AA : (k < 9 ? 32'h0101_0101 * k : 32'h0);
      chk(pkt_words[32*k +: 32] == e && pkt_done && !in_ready, "R2",
          pkt_words[32*k +: 32], e);
    end
    @(negedge clk);
    chk(!pkt_done && in_ready, "R2", pkt_done, 0);
    put(32'h0000_0000);
    @(negedge clk);
    chk(pkt_words[63:32] == 0 && pkt_len == 1, "R2", pkt_words[63:32], 0);

    // R4 uploads of several sizes, payload words look like unknown opcodes
    for (int t = 0; t < 6; t++) begin
      int w, h, n;
      w = (t == 0) ? 3 : (t == 1) ? 1 : (t == 2) ? 2 : (t == 3) ? 4 : (t == 4) ? 7 : 5;
      h = (t == 0) ? 3 : (t == 1) ? 1 : (t == 2) ? 5 : (t == 3) ? 1 : (t == 4) ? 3 : 0;
      n = (w * h + 1) / 2;
      put(32'hA000_0000); put(32'h0); put({16'(h), 16'(w)});
      @(negedge clk);
      chk(pkt_done && in_upload == (n != 0), n == 0 ? "R5" : "R4",
          in_upload, n != 0);
      for (int k = 0; k < n; k++) begin
        put(32'hFFEE_0000 + k);
        @(negedge clk);
        chk(!pkt_done && in_upload == (k != n - 1), "R4", in_upload, k != n - 1);
      end
      put(32'h0100_0000);
      @(negedge clk);
      chk(pkt_done && !bad_op && pkt_opcode == 8'h01, "R4", pkt_opcode, 8'h01);
    end

    // R6 clear mid-packet and mid-upload
    put(32'h2800_0000); put(32'h1);
    @(negedge clk); clr = 1'b1;
    #1 chk(!in_ready, "R6", in_ready, 0);
    @(negedge clk); clr = 1'b0;
    chk(pkt_len == 0 && !pkt_done && !in_upload, "R6", pkt_len, 0);
    env_cmd(32'hE600_0003);
    chk(pkt_done && pkt_len == 1 && mask_force && mask_keep, "R6", pkt_len, 1);
    put(32'hA000_0000); put(32'h0); put(32'h0003_0003); put(32'h5); put(32'h6);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    chk(!in_upload, "R6", in_upload, 0);
    env_cmd(32'hE600_0000);
    chk(pkt_done && !mask_force && !mask_keep, "R11", {mask_force, mask_keep}, 0);

    // R7 drawing mode, including the invalid depth
    for (int v = 0; v < 16384; v += 611) begin
      logic [13:0] prev;
      prev = dmode;
      env_cmd({8'hE1, 10'h2A5, 14'(v)});
      if (v[8:7] == 2'b11)
        chk(dmode == prev && bad_op, "R7", dmode, prev);
      else
        chk(dmode == 14'(v) && !bad_op && pkt_done, "R12", dmode, 14'(v));
    end
    // R8 texture window
    for (int v = 0; v < 1048576; v += 40961) begin
      env_cmd({8'hE2, 4'hF, 20'(v)});
      chk(texwin == 20'(v), "R8", texwin, 20'(v));
    end
    // R9 drawing area corners
    for (int v = 0; v < 1024; v += 97) begin
      env_cmd({8'hE3, 4'h0, 10'(1023 - v), 10'(v)});
      env_cmd({8'hE4, 4'h0, 10'(v), 10'(1023 - v)});
      chk(area_x0 == 10'(v) && area_y0 == 10'(1023 - v) &&
          area_x1 == 10'(1023 - v) && area_y1 == 10'(v), "R9", area_x0, 10'(v));
    end
    // R10 signed offsets
    for (int x = 0; x < 2048; x += 37) begin
      logic [10:0] xv, yv;
      xv = 11'(x); yv = 11'(2047 - x);
      env_cmd({8'hE5, 2'b11, yv, xv});
      chk(offs_x == {{5{xv[10]}}, xv} && offs_y == {{5{yv[10]}}, yv}, "R10",
          {offs_x, offs_y}, {{5{xv[10]}}, xv, {5{yv[10]}}, yv});
    end
    // R11 mask bits, one at a time
    env_cmd(32'hE600_0001);
    chk(mask_force && !mask_keep, "R11", {mask_force, mask_keep}, 2'b10);
    env_cmd(32'hE600_0002);
    chk(!mask_force && mask_keep, "R11", {mask_force, mask_keep}, 2'b01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule